// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block sits between a serial receiver and a host bus. Each received character arrives together with three error tags (parity, framing, break). Character and tags are stored together as one 11-bit entry in a 16-deep queue. The oldest entry is always shown on the read port, so the host reads the character and its own error status together. A host read retires the head entry. The tags of the next entry appear at once, so error status never lags the data it belongs to.

Two interrupts are produced, and both are gated by one enable input. The data interrupt fires when the fill level reaches a selectable threshold. A timeout interrupt covers a partly filled queue whose level stays below that threshold: it fires once the line has been quiet for four word lengths plus twelve bit periods. When queue mode is switched off, the block behaves as a single holding register. In that mode it interrupts on every character and has no timeout. Changing the mode empties the queue.

Top module: `rx_fifo_tagged`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `data_ready`, `overrun`, `rx_irq` and `tmo_irq` are 0, and `rd_data` and `rd_err` are 0.
- R2: In queue mode up to 16 entries are held and returned in arrival order. `rd_data`/`rd_err` show the oldest entry, and in the cycle after a `pop` they show the next entry's character and tags.
- R3: While the queue is empty, `rd_data` and `rd_err` read 0 and a `pop` leaves `level` at 0.
- R4: A push is accepted only if the queue is not full at the start of that cycle. A rejected character is discarded and `overrun` goes to 1 in the next cycle. `overrun` returns to 0 after the next successful pop.
- R5: In queue mode `rx_irq` is 1 when `level` is at least the threshold chosen by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R6: While `irq_en` is 0, both `rx_irq` and `tmo_irq` are 0. Setting `irq_en` reveals any pending condition.
- R7: With `fifo_en` at 0 the storage holds one character. `rx_irq` is 1 whenever that character is present, whatever `trig_sel` is. A second character is dropped with `overrun`, and `tmo_irq` never fires.
- R8: In queue mode with data present, `tmo_irq` becomes 1 after exactly 4*(5+`word_len`)+12 `bit_tick` pulses with no push or pop in between. `word_len` 0..3 stands for 5..8 data bits.
- R9: Any push attempt or pop restarts the timeout count and clears a pending timeout.
- R10: A change of `fifo_en` empties the queue and clears `overrun` and the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-deep queue mode, 0 = single holding register |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Data interrupt threshold select |
| word_len | input | 2 | Data bits per character minus 5 |
| bit_tick | input | 1 | One pulse per serial bit period |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_err | input | 3 | Tags: bit0 parity, bit1 framing, bit2 break |
| pop | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Head character |
| rd_err | output | 3 | Head character's error tags |
| data_ready | output | 1 | At least one entry held |
| level | output | 5 | Number of entries held |
| overrun | output | 1 | A character was dropped |
| rx_irq | output | 1 | Data interrupt |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
Assertions check on every cycle that the entry count stays within the depth, and that the single-register mode never holds more than one entry. They also check that a pop on an empty queue cannot wrap the count, that a dropped push always leaves the overrun flag set, and that the timeout flag rises only on a bit tick while data is waiting. The bench scenarios are needed for the rest: arrival order, the tag values tied to each character, the exact timeout period for every word length, each threshold setting, and the flush on a mode change.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W  = 8;
    localparam int ERR_W   = 3;
    localparam int TMO_W   = 7;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // threshold for the data interrupt in queue mode
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        case (sel)
            2'd0:    lvl = 5'd1;
            2'd1:    lvl = 5'd4;
            2'd2:    lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

    // four words of (5 + wl) data bits, plus twelve bit periods
    function automatic logic [TMO_W-1:0] tmo_limit(input logic [1:0] wl);
        logic [TMO_W-1:0] bits;
        bits = TMO_W'(5) + TMO_W'(wl);
        return (bits << 2) + TMO_W'(12);
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          wr,
    input  rx_entry_t     wdata,
    input  logic          rd,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          wr_ok
);
    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } store_t;

    store_t s_d, s_q;
    logic   rd_ok;

    always_comb begin
        s_d   = s_q;
        wr_ok = wr && (s_q.cnt < cap);
        rd_ok = rd && (s_q.cnt != '0);
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (wr_ok) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
            end
            if (rd_ok) begin
                s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
            end
            if (wr_ok && !rd_ok)
                s_d.cnt = s_q.cnt + 1'b1;
            else if (rd_ok && !wr_ok)
                s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign head  = empty ? '0 : s_q.mem[s_q.rp];

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && empty && !wr) |=> (s_q.cnt == '0));
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             active,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             flag;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart || !active) begin
            t_d.cnt  = '0;
            t_d.flag = 1'b0;
        end else if (tick && !t_q.flag) begin
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt + 1'b1 == limit)
                t_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = t_q.flag;

    // R8
    tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.flag) |-> ($past(active) && $past(tick)));
endmodule

// File: rtl/rx_fifo_tagged.sv
module rx_fifo_tagged
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              irq_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              bit_tick,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    output logic              data_ready,
    output logic [CW-1:0]     level,
    output logic              overrun,
    output logic              rx_irq,
    output logic              tmo_irq
);
    typedef struct packed {
        logic mode;
        logic ovr;
    } ctl_t;

    ctl_t      c_d, c_q;
    logic      flush;
    logic      wr_ok;
    logic      empty;
    logic      expired;
    logic [CW-1:0] cap;
    rx_entry_t wentry, head;

    assign flush  = (fifo_en != c_q.mode);
    assign cap    = c_q.mode ? CW'(DEPTH) : CW'(1);
    assign wentry = '{err: push_err, data: push_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .cap   (cap),
        .wr    (push_valid),
        .wdata (wentry),
        .rd    (pop),
        .head  (head),
        .count (level),
        .empty (empty),
        .wr_ok (wr_ok)
    );

    rxq_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .restart (push_valid || pop),
        .active  (c_q.mode && !empty && !flush),
        .limit   (tmo_limit(word_len)),
        .expired (expired)
    );

    always_comb begin
        c_d      = c_q;
        c_d.mode = fifo_en;
        if (flush)
            c_d.ovr = 1'b0;
        else if (push_valid && !wr_ok)
            c_d.ovr = 1'b1;
        else if (pop && !empty)
            c_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data    = head.data;
    assign rd_err     = head.err;
    assign data_ready = !empty;
    assign overrun    = c_q.ovr;
    assign rx_irq     = irq_en && (c_q.mode ? (level >= CW'(trig_level(trig_sel)))
                                            : !empty);
    assign tmo_irq    = irq_en && expired;

    // R7
    single_reg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.mode && !flush) |-> (level <= CW'(1)));

    // R4
    drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !wr_ok && !flush) |=> overrun);
endmodule

// File: tb/rx_fifo_tagged_test.sv
module rx_fifo_tagged_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, irq_en, bit_tick, push_valid, pop;
    logic [1:0] trig_sel, word_len;
    logic [7:0] push_data;
    logic [2:0] push_err;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic       data_ready, overrun, rx_irq, tmo_irq;
    logic [4:0] level;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_fifo_tagged uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .irq_en(irq_en),
        .trig_sel(trig_sel), .word_len(word_len), .bit_tick(bit_tick),
        .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
        .pop(pop), .rd_data(rd_data), .rd_err(rd_err), .data_ready(data_ready),
        .level(level), .overrun(overrun), .rx_irq(rx_irq), .tmo_irq(tmo_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic do_push(input logic [7:0] d, input logic [2:0] e);
        push_valid = 1'b1; push_data = d; push_err = e;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic reflush();
        fifo_en = ~fifo_en; @(negedge clk);
        fifo_en = ~fifo_en; @(negedge clk);
    endtask

    function automatic int thr(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; total++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        rst_n = 0; fifo_en = 0; irq_en = 0; trig_sel = 0; word_len = 0;
        bit_tick = 0; push_valid = 0; push_data = 0; push_err = 0; pop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", level, 0);
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 tmo_irq", tmo_irq, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 rd_err", rd_err, 0);

        fifo_en = 1; @(negedge clk);
        irq_en = 1; trig_sel = 3;

        // R2 fill in order with tags
        for (int i = 0; i < 16; i++) begin
            do_push(8'((i * 17 + 3) % 256), 3'(i % 8));
            check("R2 level", level, i + 1);
        end
        check("R5 rx_irq full", rx_irq, 1);
        // R4 drop when full
        do_push(8'hEE, 3'd7);
        check("R4 overrun", overrun, 1);
        check("R4 level", level, 16);
        for (int i = 0; i < 16; i++) begin
            check("R2 rd_data", rd_data, (i * 17 + 3) % 256);
            check("R2 rd_err", rd_err, i % 8);
            do_pop();
            if (i == 0) check("R4 overrun clear", overrun, 0);
        end
        // R3 empty head and pop on empty
        check("R3 rd_data", rd_data, 0);
        check("R3 rd_err", rd_err, 0);
        do_pop();
        check("R3 level", level, 0);
        check("R3 overrun", overrun, 0);

        // R5 threshold sweep
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int n = 1; n <= 16; n++) begin
                do_push(8'(n), 3'(s));
                check("R5 rx_irq", rx_irq, (n >= thr(s)) ? 1 : 0);
            end
            do_push(8'h55, 3'd0);
            reflush();
            // R10 flush on mode change
            check("R10 level", level, 0);
            check("R10 overrun", overrun, 0);
            check("R10 data_ready", data_ready, 0);
        end

        // R6 enable gating of data interrupt
        irq_en = 0; trig_sel = 0;
        do_push(8'h11, 3'd1);
        check("R6 rx_irq off", rx_irq, 0);
        irq_en = 1; #1;
        check("R6 rx_irq on", rx_irq, 1);
        reflush();

        // R8 timeout period per word length, R9 clear on pop
        trig_sel = 3;
        for (int wl = 0; wl < 4; wl++) begin
            int lim;
            word_len = 2'(wl);
            lim = 4 * (5 + wl) + 12;
            do_push(8'(wl), 3'd0);
            ticks(lim - 1);
            check("R8 tmo early", tmo_irq, 0);
            ticks(1);
            check("R8 tmo due", tmo_irq, 1);
            do_pop();
            check("R9 tmo pop", tmo_irq, 0);
        end

        // R9 restart on push
        word_len = 0;
        do_push(8'hA1, 3'd2);
        ticks(31);
        do_push(8'hA2, 3'd4);
        check("R9 tmo after push", tmo_irq, 0);
        ticks(31);
        check("R9 tmo restarted", tmo_irq, 0);
        ticks(1);
        check("R9 tmo due", tmo_irq, 1);
        do_pop();
        check("R9 tmo cleared", tmo_irq, 0);
        check("R2 head after pop", rd_data, 8'hA2);
        check("R2 tags after pop", rd_err, 4);
        // R6 timeout gated
        irq_en = 0;
        ticks(32);
        check("R6 tmo off", tmo_irq, 0);
        irq_en = 1; #1;
        check("R6 tmo on", tmo_irq, 1);
        do_pop();

        // R7 single holding register
        fifo_en = 0; @(negedge clk);
        trig_sel = 3;
        do_push(8'h3C, 3'd5);
        check("R7 level", level, 1);
        check("R7 rx_irq", rx_irq, 1);
        do_push(8'hC3, 3'd2);
        check("R7 overrun", overrun, 1);
        check("R7 level kept", level, 1);
        check("R7 rd_data", rd_data, 8'h3C);
        check("R7 rd_err", rd_err, 5);
        ticks(60);
        check("R7 no tmo", tmo_irq, 0);
        do_pop();
        check("R7 empty", level, 0);
        check("R7 overrun clear", overrun, 0);

        report();
        $finish;
    end
endmodule